// File: doc/BRIEF.md
# Hypercube Dimension-Order Route Unit

This block makes the forwarding decision at one node of a binary n-cube network, a network of 2^n nodes in which every node owns one link per address bit. A packet header arrives with an n-bit destination. The unit compares it against the node's own n-bit address. It then names the single outgoing link to use, or the local ejection port when the packet has already arrived. Differences are resolved from the least significant address bit upward. A packet therefore travels from 000 to 111 through 001 and 011, and never needs more than n hops.

The header enters through a ready/valid handshake. The decision is held in a register and leaves through a second ready/valid handshake, so a new header can be accepted in the same cycle that the previous decision is taken. An optional output reports how many hops remain: the number of bit positions in which the node and destination addresses differ. The parameter `DIM_W` sets n. `HOP_EN` enables the hop output; when it is disabled, that output reads zero.

Top module: `hcube_route_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` is 0 and `hdr_ready` is 1.
- R2: A header taken in a cycle (`hdr_valid` and `hdr_ready` both 1) produces `out_valid` = 1 after the next rising clock edge, carrying the decision for that header.
- R3: When the node and destination addresses differ, `out_sel` bit i is set for the lowest-numbered bit position i at which they differ, with i in 0..DIM_W-1. Bit i of `out_sel` stands for the link of dimension i.
- R4: When the node and destination addresses are equal, `out_sel` bit DIM_W (the local ejection port) is set and every dimension bit is clear.
- R5: Whenever `out_valid` is 1, exactly one bit of `out_sel` is set.
- R6: With `HOP_EN` = 1, `out_hops` equals the count of bit positions in which node and destination differ. It is therefore zero exactly when the ejection port is chosen.
- R7: While `out_valid` is 1 and `out_ready` is 0, `hdr_ready` is 0 and `out_valid`, `out_sel` and `out_hops` keep their values, whatever the header inputs do.
- R8: `hdr_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1, so a decision can be consumed and a new header accepted in one cycle.
- R9: When a decision is consumed and no header is accepted in that cycle, `out_valid` is 0 after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| node_addr | input | DIM_W | This node's address in the cube |
| hdr_valid | input | 1 | A header destination is offered |
| hdr_ready | output | 1 | The unit can take a header this cycle |
| hdr_dest | input | DIM_W | Destination address of the offered header |
| out_valid | output | 1 | A routing decision is held |
| out_ready | input | 1 | The downstream side takes the held decision |
| out_sel | output | DIM_W+1 | One-hot port choice: bit i is dimension i, bit DIM_W is local ejection |
| out_hops | output | $clog2(DIM_W+1) | Hops still to travel (zero when HOP_EN is 0) |

## Verification
The case to watch is the cycle in which the held decision drains and a fresh header is loaded at the same edge. A slip there either loses a header or repeats a stale decision. The bench provokes this by toggling `out_ready` and `hdr_valid` at random over thousands of cycles, with directed runs of back-to-back headers. A cycle-level model in the bench predicts the valid bit, the port and the hop count after every edge. That model also predicts the ready level within the same cycle, so any drop or duplicate shows up at once as a mismatch.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

  // Width needed to hold a hop count from 0 up to n inclusive.
  function automatic int unsigned hop_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/hcr_dim_pick.sv
// Lowest-differing-dimension selector: one-hot over DIM_W links plus ejection.
module hcr_dim_pick #(
  parameter int unsigned DIM_W = 4,
  localparam int unsigned SEL_W = DIM_W + 1
) (
  input  logic [DIM_W-1:0] here_addr,
  input  logic [DIM_W-1:0] dest_addr,
  output logic [DIM_W-1:0] diff_mask,
  output logic [SEL_W-1:0] port_sel
);

  // Isolate the least significant set bit with a two's-complement mask.
  function automatic logic [DIM_W-1:0] keep_lowest(input logic [DIM_W-1:0] v);
    return v & (~v + DIM_W'(1));
  endfunction

  always_comb begin
    diff_mask = here_addr ^ dest_addr;
    port_sel  = {(diff_mask == '0), keep_lowest(diff_mask)};
  end

  // Cross-check: an ascending scan over the bits must agree with the mask form.
  logic [SEL_W-1:0] scan_sel;
  always_comb begin
    logic hit;
    hit      = 1'b0;
    scan_sel = '0;
    for (int i = 0; i < int'(DIM_W); i++) begin
      if (!hit && (here_addr[i] != dest_addr[i])) begin
        scan_sel[i] = 1'b1;
        hit         = 1'b1;
      end
    end
    if (!hit) scan_sel[DIM_W] = 1'b1;
    AST_LSB_EQ_SCAN: assert (scan_sel == port_sel) else $error("lowest-bit pick differs from scan"); // R3
  end

endmodule

// File: rtl/hcr_hop_count.sv
// Remaining-hop counter: population count of the address difference.
module hcr_hop_count #(
  parameter int unsigned DIM_W = 4,
  parameter int unsigned HOP_W = 3
) (
  input  logic [DIM_W-1:0] diff_mask,
  output logic [HOP_W-1:0] hop_cnt
);

  function automatic logic [HOP_W-1:0] ones_in(input logic [DIM_W-1:0] v);
    logic [HOP_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < int'(DIM_W); i++) acc = acc + HOP_W'(v[i]);
    return acc;
  endfunction

  assign hop_cnt = ones_in(diff_mask);

endmodule

// File: rtl/hcr_out_stage.sv
// Single decision register with ready/valid on both sides.
module hcr_out_stage #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);

  logic take_in;
  logic drain;

  assign in_ready = !out_valid || out_ready;
  assign take_in  = in_valid && in_ready;
  assign drain    = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take_in) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (drain) begin
      out_valid <= 1'b0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !out_valid); // R1

  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R9

endmodule

// File: rtl/hcube_route_unit.sv
// Per-node dimension-order routing decision for a binary n-cube.
module hcube_route_unit #(
  parameter int unsigned DIM_W  = 4,
  parameter bit          HOP_EN = 1'b1,
  localparam int unsigned SEL_W = DIM_W + 1,
  localparam int unsigned HOP_W = hcr_pkg::hop_width(DIM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] node_addr,
  input  logic             hdr_valid,
  output logic             hdr_ready,
  input  logic [DIM_W-1:0] hdr_dest,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SEL_W-1:0] out_sel,
  output logic [HOP_W-1:0] out_hops
);

  localparam int unsigned PW = SEL_W + HOP_W;

  logic [DIM_W-1:0] diff_mask;
  logic [SEL_W-1:0] next_sel;
  logic [HOP_W-1:0] next_hops;
  logic [PW-1:0]    next_word;
  logic [PW-1:0]    held_word;

  hcr_dim_pick #(.DIM_W(DIM_W)) pick_i (
    .here_addr (node_addr),
    .dest_addr (hdr_dest),
    .diff_mask (diff_mask),
    .port_sel  (next_sel)
  );

  generate
    if (HOP_EN) begin : g_hops
      hcr_hop_count #(.DIM_W(DIM_W), .HOP_W(HOP_W)) cnt_i (
        .diff_mask (diff_mask),
        .hop_cnt   (next_hops)
      );
    end else begin : g_no_hops
      assign next_hops = '0;
    end
  endgenerate

  assign next_word = {next_sel, next_hops};

  hcr_out_stage #(.PW(PW)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (hdr_valid),
    .in_ready  (hdr_ready),
    .in_data   (next_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (held_word)
  );

  assign out_sel  = held_word[PW-1:HOP_W];
  assign out_hops = held_word[HOP_W-1:0];

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_sel) == 1)); // R5

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !hdr_ready); // R7

  generate
    if (HOP_EN) begin : g_hop_chk
      AST_EJECT_ZERO_HOPS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sel[DIM_W] == (out_hops == '0))); // R6
    end
  endgenerate

endmodule

// File: tb/hcube_route_unit_tb.sv
module hcube_route_unit_tb_top;

  localparam int unsigned W  = 4;
  localparam int unsigned SW = W + 1;
  localparam int unsigned HW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  node_addr = '0;
  logic          hdr_valid = 1'b0;
  logic          hdr_ready;
  logic [W-1:0]  hdr_dest = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [SW-1:0] out_sel;
  logic [HW-1:0] out_hops;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic          m_valid = 1'b0;
  logic [SW-1:0] m_sel   = '0;
  logic [HW-1:0] m_hops  = '0;

  always #2 clk = ~clk;

  hcube_route_unit #(.DIM_W(W), .HOP_EN(1'b1)) dut_i (
    .clk, .rst_n, .node_addr, .hdr_valid, .hdr_ready, .hdr_dest,
    .out_valid, .out_ready, .out_sel, .out_hops
  );

  // Expected port: walk dimensions upward, first mismatch wins.
  function automatic logic [SW-1:0] want_sel(input logic [W-1:0] a, input logic [W-1:0] b);
    for (int d = 0; d < int'(W); d++)
      if (a[d] != b[d]) return SW'(1) << d;
    return SW'(1) << W;
  endfunction

  function automatic logic [HW-1:0] want_hops(input logic [W-1:0] a, input logic [W-1:0] b);
    int c = 0;
    for (int d = 0; d < int'(W); d++) if (a[d] != b[d]) c++;
    return HW'(c);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: check state from last edge, drive inputs, check ready, update model.
  task automatic cyc(input logic hv, input logic [W-1:0] dst, input logic [W-1:0] nd, input logic ordy);
    logic er;
    @(negedge clk);
    chk(out_valid == m_valid, "R2/R9 valid", int'(out_valid), int'(m_valid));
    if (m_valid) begin
      chk(out_sel == m_sel, m_sel[W] ? "R4/R7 sel" : "R3/R7 sel", int'(out_sel), int'(m_sel));
      chk($countones(out_sel) == 1, "R5 onehot", int'(out_sel), 1);
      chk(out_hops == m_hops, "R6 hops", int'(out_hops), int'(m_hops));
    end
    hdr_valid = hv; hdr_dest = dst; node_addr = nd; out_ready = ordy;
    #1;
    er = !m_valid || ordy;
    chk(hdr_ready == er, "R8/R7 ready", int'(hdr_ready), int'(er));
    if (hv && er) begin
      m_valid = 1'b1;
      m_sel   = want_sel(nd, dst);
      m_hops  = want_hops(nd, dst);
    end else if (m_valid && ordy) begin
      m_valid = 1'b0;
    end
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] nd;
    void'($urandom(32'd4242));
    #5;
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    chk(hdr_ready == 1'b1, "R1 ready in reset", int'(hdr_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    chk(hdr_ready == 1'b1, "R1 ready after reset", int'(hdr_ready), 1);

    // R3: path 0000 -> 1111, each step flips the lowest differing bit
    nd = 4'b0000;
    for (int s = 0; s < 4; s++) begin
      cyc(1'b1, 4'b1111, nd, 1'b1);
      nd = nd | W'(1 << s);
    end
    // R4: arrived at destination
    cyc(1'b1, 4'b1111, 4'b1111, 1'b1);
    // R3: only the top bit differs
    cyc(1'b1, 4'b1000, 4'b0000, 1'b1);
    cyc(1'b0, 4'b0000, 4'b0000, 1'b1);
    cyc(1'b0, 4'b0000, 4'b0000, 1'b1);   // R9 drained
    // R7: load then stall while header inputs churn
    cyc(1'b1, 4'b0110, 4'b0000, 1'b0);
    for (int s = 0; s < 5; s++) cyc(1'b1, W'(s), 4'b1111, 1'b0);
    cyc(1'b1, 4'b0101, 4'b0101, 1'b1);   // R8 consume + accept together
    cyc(1'b0, 4'b0000, 4'b0000, 1'b1);
    cyc(1'b0, 4'b0000, 4'b0000, 1'b1);

    // constrained random traffic
    for (int k = 0; k < 4000; k++) begin
      cyc(($urandom % 4) != 0, W'($urandom), W'($urandom), ($urandom % 3) != 0);
    end
    cyc(1'b0, '0, '0, 1'b1);
    cyc(1'b0, '0, '0, 1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule